// File: doc/BRIEF.md
# Correlator Frame Control Generator

This block produces the three timing strobes that pace a correlator engine: a frame-start marker, an accumulate enable and a shift enable. It counts valid samples, qualified by a sample-enable input. Each correlator frame lasts a whole multiple of a base sample count. The frame-start marker covers the opening samples of every frame. The two enables pulse at independent power-of-two spacings, phased to the first sample after the marker drops. Configuration arrives on static inputs and is taken up at the first sample of each frame.

The sample-enable input may drop for any number of cycles, for example while the data source inserts non-data bits. Counting, the marker window and the enable phasing all stall with it. A once-per-second tick input re-aligns the frame grid. If the tick arrives while the grid is already aligned, nothing changes. If it arrives mid-frame, the frame in progress runs to at least its full length, and it ends on the first sample that falls on the tick's grid. No shortened frame is ever emitted. Without ticks the grid free-runs.

Top module: `corr_frame_ctrl`

## Requirements
- R1: A frame, absent re-alignment, lasts exactly (M+1)*UNIT valid samples, where M is `cfg_frame_mult` taken at the frame's first sample. No frame is ever shorter than that.
- R2: `bocf` is high for the first BOCF_LEN valid samples of each frame, including the cycles between them where `samp_en` is low, and low for the rest of the frame.
- R3: With `cfg_add_exp` = k > 0, `enadd` is high only in cycles with `samp_en` high, outside the `bocf` window, at frame positions BOCF_LEN + j*2^k (position 0 is a frame's first sample).
- R4: `enshft` follows the same rule as R3, independently, using `cfg_shift_exp`.
- R5: An exponent of 0 holds the corresponding enable high in every cycle, whatever the state of `samp_en` and `bocf`.
- R6: Frame position advances only in cycles where `samp_en` is high. Outputs gated by position hold their values while it is low.
- R7: A rising edge of `pps` in a cycle whose next sample is position 0 of a frame leaves the frame sequence unchanged.
- R8: On a rising edge of `pps` elsewhere, the sample taken in that cycle (or the next valid sample, if `samp_en` is low) becomes position 0 of a tick-aligned grid. The current frame continues past its normal end until the grid's frame boundary, and the following frames start on that grid.
- R9: With no `pps` edges, frames repeat back to back indefinitely.
- R10: Changes to `cfg_frame_mult`, `cfg_add_exp` and `cfg_shift_exp` made after a frame's first sample affect only later frames.
- R11: After reset the next sample is position 0: `bocf` is high and an enable with a nonzero exponent is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_en | input | 1 | A valid sample is present this cycle |
| pps | input | 1 | Once-per-second tick; rising edge detected |
| cfg_frame_mult | input | MULT_W | Frame length is (value+1)*UNIT samples |
| cfg_add_exp | input | EXP_W | Accumulate-enable period exponent k (0 = held high) |
| cfg_shift_exp | input | EXP_W | Shift-enable period exponent k (0 = held high) |
| bocf | output | 1 | Frame-start window |
| enadd | output | 1 | Accumulate enable |
| enshft | output | 1 | Shift enable |

## Verification
A position counter that is off by even one sample shows at the ports within one frame. The marker edge and the first enable pulse move together relative to the sample stream, so a cycle-by-cycle comparison catches the error at the next boundary. A lost or stuck pending-realignment flag shows up differently. It either cuts a frame short at the normal end or fails to move the grid onto the tick, and the first frame after the tick exposes either fault. An exponent or period latched at the wrong time changes the pulse spacing or the frame length in the frame where the configuration was altered.

// File: rtl/corr_frame_ctrl.sv
module corr_frame_ctrl #(
  parameter int UNIT     = 125000,
  parameter int BOCF_LEN = 256,
  parameter int MULT_W   = 8,
  parameter int EXP_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              pps,
  input  logic [MULT_W-1:0] cfg_frame_mult,
  input  logic [EXP_W-1:0]  cfg_add_exp,
  input  logic [EXP_W-1:0]  cfg_shift_exp,
  output logic              bocf,
  output logic              enadd,
  output logic              enshft
);
  localparam int MAX_LEN = (2 ** MULT_W) * UNIT;
  localparam int CNT_W   = $clog2(2 * MAX_LEN);
  localparam logic [CNT_W-1:0] UNIT_C = CNT_W'(UNIT);
  localparam logic [CNT_W-1:0] BL_C   = CNT_W'(BOCF_LEN);

  logic [CNT_W-1:0]  cnt, sh, last;
  logic              pend, pps_q, pps_edge, frame_end, at_start;
  logic [MULT_W-1:0] mult_q, mult_eff;
  logic [EXP_W-1:0]  add_exp_q, shift_exp_q, add_eff, shift_eff;

  assign at_start  = (cnt == '0);
  assign mult_eff  = at_start ? cfg_frame_mult : mult_q;
  assign add_eff   = at_start ? cfg_add_exp    : add_exp_q;
  assign shift_eff = at_start ? cfg_shift_exp  : shift_exp_q;
  assign last      = (CNT_W'(mult_eff) + 1'b1) * UNIT_C - 1'b1;
  assign pps_edge  = pps & ~pps_q;
  assign frame_end = pend ? (cnt >= last && sh == last) : (cnt == last);

  function automatic logic strobe(input logic [EXP_W-1:0] e, input logic [CNT_W-1:0] c,
                                  input logic en);
    logic [CNT_W-1:0] mask;
    mask = (CNT_W'(1) << e) - 1'b1;
    return (e == '0) || (en && c >= BL_C && ((c - BL_C) & mask) == '0);
  endfunction

  assign bocf   = cnt < BL_C;
  assign enadd  = strobe(add_eff, cnt, samp_en);
  assign enshft = strobe(shift_eff, cnt, samp_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      sh          <= '0;
      pend        <= 1'b0;
      pps_q       <= 1'b0;
      mult_q      <= '0;
      add_exp_q   <= '0;
      shift_exp_q <= '0;
    end else begin
      pps_q <= pps;
      if (samp_en) begin
        if (at_start) begin
          mult_q      <= cfg_frame_mult;
          add_exp_q   <= cfg_add_exp;
          shift_exp_q <= cfg_shift_exp;
        end
        cnt <= frame_end ? '0 : cnt + 1'b1;
        if (pend) sh <= (sh == last) ? '0 : sh + 1'b1;
      end
      if (pps_edge) begin
        pend <= !at_start;
        sh   <= samp_en ? CNT_W'(1) : '0;
      end else if (samp_en && frame_end) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/corr_frame_ctrl_chk.sv
module corr_frame_ctrl_chk #(
  parameter int CNT_W = 8,
  parameter int MULT_W = 8,
  parameter int EXP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              samp_en,
  input logic              bocf,
  input logic              enadd,
  input logic              pps_edge,
  input logic              pend,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  last,
  input logic [MULT_W-1:0] mult_q,
  input logic [EXP_W-1:0]  add_exp_q
);
  // R1
  full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && $past(cnt) != '0) |-> ($past(samp_en) && $past(cnt) >= $past(last)));
  // R3
  add_pulse_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_exp_q != '0 && cnt != '0 && enadd) |-> (samp_en && !bocf));
  // R5
  add_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_exp_q == '0 && cnt != '0) |-> enadd);
  // R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(cnt));
  // R7
  aligned_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_edge && cnt == '0) |=> !pend);
  // R10
  cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_q != $past(mult_q)) |-> ($past(cnt) == '0 && $past(samp_en)));
endmodule

bind corr_frame_ctrl corr_frame_ctrl_chk #(.CNT_W(CNT_W), .MULT_W(MULT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .bocf(bocf), .enadd(enadd),
  .pps_edge(pps_edge), .pend(pend), .cnt(cnt), .last(last),
  .mult_q(mult_q), .add_exp_q(add_exp_q)
);

// File: tb/tb_corr_frame_ctrl.sv
module tb_corr_frame_ctrl;
  localparam int UNIT = 20;
  localparam int BL   = 4;

  logic clk = 0, rst_n = 0, samp_en = 0, pps = 0;
  logic [7:0] cfg_frame_mult = 8'd1;
  logic [2:0] cfg_add_exp = 3'd2, cfg_shift_exp = 3'd3;
  logic bocf, enadd, enshft;

  corr_frame_ctrl #(.UNIT(UNIT), .BOCF_LEN(BL), .MULT_W(8), .EXP_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .pps(pps),
    .cfg_frame_mult(cfg_frame_mult), .cfg_add_exp(cfg_add_exp),
    .cfg_shift_exp(cfg_shift_exp), .bocf(bocf), .enadd(enadd), .enshft(enshft));

  always #10 clk = ~clk;

  typedef struct { bit b; bit a; bit s; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  string phase = "R11";

  int pos = 0, sh = 0, mq = 0, aq = 0, sq = 0;
  bit pend = 0, pq = 0;

  function automatic bit pulse(int k, int p, bit en);
    if (k == 0) return 1;
    return en && p >= BL && ((p - BL) % (1 << k)) == 0;
  endfunction

  task automatic step(input bit en, input bit p);
    exp_t e;
    int m, a, s, len, npos;
    bit edge_seen, bound;
    @(posedge clk); #2;
    samp_en = en; pps = p;
    edge_seen = p && !pq;
    m = (pos == 0) ? int'(cfg_frame_mult) : mq;
    a = (pos == 0) ? int'(cfg_add_exp) : aq;
    s = (pos == 0) ? int'(cfg_shift_exp) : sq;
    len = (m + 1) * UNIT;
    e.b = pos < BL; e.a = pulse(a, pos, en); e.s = pulse(s, pos, en); e.tag = phase;
    sb.push_back(e);
    bound = 0; npos = pos;
    if (en) begin
      if (pos == 0) begin mq = m; aq = a; sq = s; end
      bound = pend ? (pos >= len - 1 && sh == len - 1) : (pos == len - 1);
      npos = bound ? 0 : pos + 1;
      if (pend) sh = (sh == len - 1) ? 0 : sh + 1;
    end
    if (edge_seen) begin pend = (pos != 0); sh = en ? 1 : 0; end
    else if (en && bound) pend = 0;
    pos = npos; pq = p;
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if ({bocf, enadd, enshft} !== {e.b, e.a, e.s}) begin
        fails++;
        $display("FAIL %s: bocf/enadd/enshft got %b%b%b expected %b%b%b",
                 e.tag, bocf, enadd, enshft, e.b, e.a, e.s);
      end
    end
  end

  task automatic run(input int n, input bit gaps);
    for (int i = 0; i < n; i++) step(gaps ? ((i % 3) != 1 && (i % 7) != 5) : 1'b1, 1'b0);
  endtask

  task automatic go_to(input int target);
    for (int i = 0; i < 4000 && pos != target; i++) step(1'b1, 1'b0);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    @(negedge clk);
    checks++;
    // R11 reset state
    if (bocf !== 1'b1 || enadd !== 1'b0 || enshft !== 1'b0) begin
      fails++;
      $display("FAIL R11: got %b%b%b expected 100", bocf, enadd, enshft);
    end
    phase = "R1 R2 R3 R4 basic frames";   run(130, 0);
    phase = "R6 paused samples";          run(200, 1);
    go_to(5);
    phase = "R10 cfg change mid frame";
    cfg_frame_mult = 8'd2; cfg_add_exp = 3'd1; cfg_shift_exp = 3'd2;
    run(160, 0);
    go_to(10);
    phase = "R5 zero exponent held high";
    cfg_add_exp = 3'd0; cfg_shift_exp = 3'd7;
    run(200, 1);
    cfg_add_exp = 3'd3; cfg_shift_exp = 3'd0;
    run(150, 0);
    cfg_frame_mult = 8'd1; cfg_add_exp = 3'd2; cfg_shift_exp = 3'd1;
    go_to(0);
    phase = "R7 aligned tick";
    step(1'b1, 1'b1); step(1'b1, 1'b0); run(100, 0);
    go_to(17);
    phase = "R8 mid-frame tick";
    step(1'b1, 1'b1); step(1'b1, 1'b0); run(200, 0);
    go_to(35);
    phase = "R8 tick near frame end with gaps";
    step(1'b0, 1'b1); step(1'b1, 1'b1); run(220, 1);
    go_to(3);
    phase = "R8 tick in marker window";
    step(1'b1, 1'b1); run(150, 0);
    phase = "R9 free running";            run(600, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule